// File: doc/BRIEF.md
# Byte-wide host port slave

This block lets an external host with an 8-bit data bus reach a local memory of 16-bit words. The host sees three registers: a 16-bit control register, an address pointer into the word memory, and a data latch through which memory words are read and written. Two select pins choose the register for each byte access, a read/write line gives the direction, and a one-cycle strobe qualifies the access on a rising clock edge. Every 16-bit word crosses the port as two consecutive byte cycles, and a byte-identification input marks whether the current cycle carries the first or the second byte of the word.

A byte-order bit in the control register decides whether the first byte of a word is its high or its low half. Data accesses come in two flavours: one leaves the pointer alone, the other advances it by one word, after the fetch on a read and ahead of the store on a write, so a host can set the pointer once and stream a contiguous block of words in either direction. The word memory (256 words by default) stands in for the local processor's memory. A local-side port lets the local processor write and read the control register.

Top module: `bytehost_port`

## Requirements
- R1: After reset the control register reads 0 on the local port, the address pointer is 0 and the host read bus `host_dout` is 0.
- R2: A host control write (select 00) takes effect as a whole word on the second byte; after only the first byte the control register is unchanged. Writing the same byte twice yields that byte in both halves.
- R3: A local write sets the control register, visible on `loc_rdata` from the next cycle; when it collides with a host second-byte control write in the same cycle, the host value wins.
- R4: Control bit 0 is the byte order, reset value 0: when 0 the first byte of every word (reads and writes, all registers) is bits 15:8; when 1 it is bits 7:0.
- R5: A host address write (select 10) loads the low log2(DEPTH) bits of the word into the pointer on the second byte; a host address read returns the pointer zero-extended to 16 bits.
- R6: A data write with select 11 stores the word at the current pointer on the second byte and leaves the pointer unchanged; a data read with select 11 returns the word at the pointer without moving it.
- R7: A data write with select 01 first advances the pointer by one and stores the word at the advanced address.
- R8: A data read with select 01 returns the word at the current pointer and advances the pointer by one after the second byte.
- R9: `host_dout` changes only on the clock edge that takes a strobed read byte and holds its value at all other times.
- R10: The pointer wraps from DEPTH-1 to 0 when it advances.
- R11: Cycles without the strobe change neither the pointer, the memory nor the control register, and a write word whose second byte never arrives leaves memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_sel | input | 2 | Register select: 00 control, 01 data with advance, 10 address, 11 data fixed |
| host_rnw | input | 1 | 1 = host read, 0 = host write |
| host_strobe | input | 1 | Qualifies one byte access on the rising edge |
| host_second | input | 1 | 0 = first byte of the word, 1 = second byte |
| host_din | input | 8 | Write byte from the host |
| host_dout | output | 8 | Registered read byte to the host |
| loc_wr | input | 1 | Local write strobe for the control register |
| loc_wdata | input | 16 | Local write value for the control register |
| loc_rdata | output | 16 | Current control register value |

## Verification
Every result is due one clock edge after the strobed byte cycle that causes it: a read byte appears on `host_dout` and the pointer, memory and control register take their new values at the edge that samples the second byte. The bench drives each byte on a falling edge, holds it across exactly one rising edge, and samples outputs on the following falling edge, so each check reads the state one register stage after its stimulus. Reset release passes through a two-stage synchronizer, so the bench waits several cycles after deasserting reset before the first access. Memory and pointer effects are observed only through host reads of the data and address registers.

// File: rtl/bhp_pkg.sv
package bhp_pkg;

  typedef enum logic [1:0] {
    HSEL_CTRL     = 2'b00,
    HSEL_DATA_INC = 2'b01,
    HSEL_ADDR     = 2'b10,
    HSEL_DATA_FIX = 2'b11
  } hsel_e;

  typedef struct packed {
    logic hold_wr;
    logic ctrl_wr;
    logic addr_wr;
    logic data_wr;
    logic data_rd_first;
    logic bump;
    logic rd_any;
  } hevt_t;

  // High half is on the bus when the byte position equals the order bit.
  function automatic logic hi_lane(input logic second, input logic order);
    return (second == order);
  endfunction

endpackage

// File: rtl/bhp_decode.sv
module bhp_decode
  import bhp_pkg::*;
#(
  parameter int BW = 8,
  parameter int DW = 2 * BW
) (
  input  logic          strobe,
  input  logic          rnw,
  input  logic          second,
  input  logic [1:0]    sel,
  input  logic          order,
  input  logic [BW-1:0] din,
  input  logic [BW-1:0] hold_q,
  output hevt_t         evt,
  output logic [DW-1:0] wword
);

  hsel_e hsel;
  logic  is_data;
  logic  wr_first;
  logic  wr_second;
  logic  rd_strobe;

  always_comb begin
    hsel      = hsel_e'(sel);
    is_data   = (hsel == HSEL_DATA_INC) || (hsel == HSEL_DATA_FIX);
    wr_first  = strobe && !rnw && !second;
    wr_second = strobe && !rnw && second;
    rd_strobe = strobe && rnw;

    evt.hold_wr       = wr_first;
    evt.ctrl_wr       = wr_second && (hsel == HSEL_CTRL);
    evt.addr_wr       = wr_second && (hsel == HSEL_ADDR);
    evt.data_wr       = wr_second && is_data;
    evt.data_rd_first = rd_strobe && !second && is_data;
    evt.bump          = strobe && second && (hsel == HSEL_DATA_INC);
    evt.rd_any        = rd_strobe;

    if (order) begin
      wword = {din, hold_q};
    end else begin
      wword = {hold_q, din};
    end
  end

endmodule

// File: rtl/bhp_ptr.sv
module bhp_ptr #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          bump,
  output logic [AW-1:0] ptr_q,
  output logic [AW-1:0] ptr_inc
);

  logic [AW-1:0] ptr_d;
  logic          ptr_en;

  always_comb begin
    ptr_inc = ptr_q + AW'(1);
    ptr_en  = load || bump;
    if (load) begin
      ptr_d = load_val;
    end else if (bump) begin
      ptr_d = ptr_inc;
    end else begin
      ptr_d = ptr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

endmodule

// File: rtl/bhp_wordmem.sv
module bhp_wordmem #(
  parameter int DEPTH = 256,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      cells[waddr] <= wdata;
    end
  end

  always_comb begin
    rdata = cells[raddr];
  end

endmodule

// File: rtl/bytehost_port.sv
module bytehost_port
  import bhp_pkg::*;
#(
  parameter int DEPTH       = 256,
  parameter int BW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      host_sel,
  input  logic            host_rnw,
  input  logic            host_strobe,
  input  logic            host_second,
  input  logic [BW-1:0]   host_din,
  output logic [BW-1:0]   host_dout,
  input  logic            loc_wr,
  input  logic [2*BW-1:0] loc_wdata,
  output logic [2*BW-1:0] loc_rdata
);

  localparam int DW = 2 * BW;
  localparam int AW = $clog2(DEPTH);

  // Reset: asserted asynchronously, released after SYNC_STAGES edges.
  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe_q[SYNC_STAGES-1];

  // State
  logic [DW-1:0] ctrl_q, ctrl_d;
  logic [BW-1:0] hold_q, hold_d;
  logic [DW-1:0] latch_q, latch_d;
  logic [BW-1:0] dout_q, dout_d;
  logic          ctrl_en;

  hevt_t         evt;
  logic [DW-1:0] wword;
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] ptr_inc;
  logic [AW-1:0] mem_waddr;
  logic [DW-1:0] mem_rdata;
  logic [DW-1:0] src_word;
  logic          order;
  hsel_e         hsel;

  assign order = ctrl_q[0];

  bhp_decode #(
    .BW (BW),
    .DW (DW)
  ) u_decode (
    .strobe (host_strobe),
    .rnw    (host_rnw),
    .second (host_second),
    .sel    (host_sel),
    .order  (order),
    .din    (host_din),
    .hold_q (hold_q),
    .evt    (evt),
    .wword  (wword)
  );

  bhp_ptr #(
    .AW (AW)
  ) u_ptr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (evt.addr_wr),
    .load_val (wword[AW-1:0]),
    .bump     (evt.bump),
    .ptr_q    (ptr_q),
    .ptr_inc  (ptr_inc)
  );

  // Write side advances ahead of the store; read side advances afterwards.
  assign mem_waddr = evt.bump ? ptr_inc : ptr_q;

  bhp_wordmem #(
    .DEPTH (DEPTH),
    .DW    (DW)
  ) u_mem (
    .clk   (clk),
    .we    (evt.data_wr),
    .waddr (mem_waddr),
    .wdata (wword),
    .raddr (ptr_q),
    .rdata (mem_rdata)
  );

  // Next-state logic
  always_comb begin
    hsel    = hsel_e'(host_sel);
    ctrl_en = evt.ctrl_wr || loc_wr;
    if (evt.ctrl_wr) begin
      ctrl_d = wword;
    end else if (loc_wr) begin
      ctrl_d = loc_wdata;
    end else begin
      ctrl_d = ctrl_q;
    end

    hold_d  = evt.hold_wr ? host_din : hold_q;
    latch_d = evt.data_rd_first ? mem_rdata : latch_q;

    unique case (hsel)
      HSEL_CTRL: src_word = ctrl_q;
      HSEL_ADDR: src_word = DW'(ptr_q);
      default:   src_word = host_second ? latch_q : mem_rdata;
    endcase

    dout_d = dout_q;
    if (evt.rd_any) begin
      dout_d = hi_lane(host_second, order) ? src_word[DW-1:BW] : src_word[BW-1:0];
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctrl_q  <= '0;
      hold_q  <= '0;
      latch_q <= '0;
      dout_q  <= '0;
    end else begin
      if (ctrl_en) begin
        ctrl_q <= ctrl_d;
      end
      if (evt.hold_wr) begin
        hold_q <= hold_d;
      end
      if (evt.data_rd_first) begin
        latch_q <= latch_d;
      end
      if (evt.rd_any) begin
        dout_q <= dout_d;
      end
    end
  end

  assign host_dout = dout_q;
  assign loc_rdata = ctrl_q;

endmodule

// File: rtl/bhp_checker.sv
module bhp_checker #(
  parameter int AW = 8,
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    host_sel,
  input logic          host_rnw,
  input logic          host_strobe,
  input logic          host_second,
  input logic          loc_wr,
  input logic [AW-1:0] ptr_q,
  input logic [2*BW-1:0] ctrl_q,
  input logic [BW-1:0] host_dout
);

  AST_PTR_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !host_strobe |=> $stable(ptr_q)); // R11

  AST_PTR_FIXED_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (host_strobe && host_sel == 2'b11) |=> $stable(ptr_q)); // R6

  AST_PTR_BUMP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_strobe && !host_rnw && host_second && host_sel == 2'b01)
      |=> (ptr_q == $past(ptr_q) + AW'(1))); // R7

  AST_PTR_BUMP_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (host_strobe && host_rnw && host_second && host_sel == 2'b01)
      |=> (ptr_q == $past(ptr_q) + AW'(1))); // R8

  AST_CTRL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!loc_wr && !(host_strobe && !host_rnw && host_second && host_sel == 2'b00))
      |=> $stable(ctrl_q)); // R2

  AST_DOUT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_strobe && host_rnw) |=> $stable(host_dout)); // R9

endmodule

bind bytehost_port bhp_checker #(
  .AW (AW),
  .BW (BW)
) u_bhp_checker (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .host_sel    (host_sel),
  .host_rnw    (host_rnw),
  .host_strobe (host_strobe),
  .host_second (host_second),
  .loc_wr      (loc_wr),
  .ptr_q       (ptr_q),
  .ctrl_q      (ctrl_q),
  .host_dout   (host_dout)
);

// File: tb/bytehost_port_bench.sv
`timescale 1ns/1ps
module bytehost_port_bench;

  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  host_sel;
  logic        host_rnw;
  logic        host_strobe;
  logic        host_second;
  logic [7:0]  host_din;
  logic [7:0]  host_dout;
  logic        loc_wr;
  logic [15:0] loc_wdata;
  logic [15:0] loc_rdata;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;
  logic ord = 1'b0;

  always #4 clk = ~clk;

  bytehost_port #(.DEPTH(DEPTH)) u_bytehost_port (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_rnw(host_rnw),
    .host_strobe(host_strobe), .host_second(host_second), .host_din(host_din),
    .host_dout(host_dout), .loc_wr(loc_wr), .loc_wdata(loc_wdata),
    .loc_rdata(loc_rdata)
  );

  function automatic logic [15:0] pat(input int i);
    return 16'((i * 16'h0107) ^ 16'hA55A);
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic hbyte(input logic [1:0] sel, input logic rnw, input logic sec,
                       input logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    host_sel = sel; host_rnw = rnw; host_second = sec; host_din = d; host_strobe = 1'b1;
    @(negedge clk);
    host_strobe = 1'b0;
    q = host_dout;
  endtask

  task automatic wr_word(input logic [1:0] sel, input logic [15:0] w);
    logic [7:0] q;
    hbyte(sel, 1'b0, 1'b0, ord ? w[7:0] : w[15:8], q);
    hbyte(sel, 1'b0, 1'b1, ord ? w[15:8] : w[7:0], q);
  endtask

  task automatic rd_word(input logic [1:0] sel, output logic [15:0] w);
    logic [7:0] b0, b1;
    hbyte(sel, 1'b1, 1'b0, 8'h00, b0);
    hbyte(sel, 1'b1, 1'b1, 8'h00, b1);
    w = ord ? {b1, b0} : {b0, b1};
  endtask

  task automatic loc_write(input logic [15:0] v);
    @(negedge clk);
    loc_wr = 1'b1; loc_wdata = v;
    @(negedge clk);
    loc_wr = 1'b0;
    ord = v[0];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    logic [7:0]  q, q0;
    rst_n = 1'b0; host_sel = '0; host_rnw = 1'b0; host_strobe = 1'b0;
    host_second = 1'b0; host_din = '0; loc_wr = 1'b0; loc_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 ctrl", loc_rdata, 16'h0000);
    chk("R1 dout", {8'h00, host_dout}, 16'h0000);
    rd_word(2'b10, w);
    chk("R1 pointer", w, 16'h0000);

    // R2 control write, first byte only then second
    hbyte(2'b00, 1'b0, 1'b0, 8'h5A, q);
    chk("R2 after first byte", loc_rdata, 16'h0000);
    hbyte(2'b00, 1'b0, 1'b1, 8'h5A, q);
    chk("R2 after second byte", loc_rdata, 16'h5A5A);

    // R3 local write and collision
    loc_write(16'h1234);
    chk("R3 local write", loc_rdata, 16'h1234);
    hbyte(2'b00, 1'b0, 1'b0, 8'h22, q);
    @(negedge clk);
    host_sel = 2'b00; host_rnw = 1'b0; host_second = 1'b1; host_din = 8'h22;
    host_strobe = 1'b1; loc_wr = 1'b1; loc_wdata = 16'hFFFF;
    @(negedge clk);
    host_strobe = 1'b0; loc_wr = 1'b0;
    chk("R3 host wins collision", loc_rdata, 16'h2222);

    // R4 control read, order 0: first byte is high half
    loc_write(16'hC3A4);
    hbyte(2'b00, 1'b1, 1'b0, 8'h00, q0);
    hbyte(2'b00, 1'b1, 1'b1, 8'h00, q);
    chk("R4 ctrl first byte high", {8'h00, q0}, 16'h00C3);
    chk("R4 ctrl second byte low", {8'h00, q}, 16'h00A4);

    // R5 address load and readback, upper bits dropped
    wr_word(2'b10, 16'h0010);
    rd_word(2'b10, w);
    chk("R5 pointer readback", w, 16'h0010);
    wr_word(2'b10, 16'hAB37);
    rd_word(2'b10, w);
    chk("R5 pointer truncated", w, 16'h0037);

    // R6 fixed write at top address, pointer unchanged
    wr_word(2'b10, 16'(DEPTH - 1));
    wr_word(2'b11, 16'hBEEF);
    rd_word(2'b10, w);
    chk("R6 pointer after fixed write", w, 16'(DEPTH - 1));
    rd_word(2'b11, w);
    chk("R6 fixed read", w, 16'hBEEF);
    rd_word(2'b10, w);
    chk("R6 pointer after fixed read", w, 16'(DEPTH - 1));

    // R7/R10 streaming write with pre-advance from DEPTH-1 wraps to 0 first
    for (int i = 0; i < DEPTH; i++) wr_word(2'b01, pat(i));
    rd_word(2'b10, w);
    chk("R7 R10 pointer after stream write", w, 16'(DEPTH - 1));

    // R8/R10 streaming read with post-advance
    wr_word(2'b10, 16'h0000);
    for (int i = 0; i < DEPTH; i++) begin
      rd_word(2'b01, w);
      chk($sformatf("R8 stream read word %0d", i), w, pat(i));
    end
    rd_word(2'b10, w);
    chk("R8 R10 pointer wrapped", w, 16'h0000);

    // R4 order 1: first byte is low half, on read and write
    loc_write(16'h0001);
    wr_word(2'b10, 16'h0005);
    hbyte(2'b11, 1'b1, 1'b0, 8'h00, q0);
    chk("R4 order1 first read byte low", {8'h00, q0}, {8'h00, pat(5)[7:0]});
    hbyte(2'b11, 1'b0, 1'b0, 8'h57, q);
    hbyte(2'b11, 1'b0, 1'b1, 8'h13, q);
    loc_write(16'h0000);
    hbyte(2'b11, 1'b1, 1'b0, 8'h00, q0);
    chk("R4 order1 write placed low first", {8'h00, q0}, 16'h0013);

    // R11 incomplete write and unstrobed cycles
    wr_word(2'b10, 16'h0007);
    hbyte(2'b11, 1'b0, 1'b0, 8'hEE, q);
    @(negedge clk);
    host_sel = 2'b01; host_rnw = 1'b0; host_second = 1'b1; host_din = 8'h99;
    repeat (3) @(negedge clk);
    @(negedge clk);
    host_sel = 2'b00;
    repeat (2) @(negedge clk);
    chk("R11 ctrl untouched", loc_rdata, 16'h0000);
    rd_word(2'b10, w);
    chk("R11 pointer untouched", w, 16'h0007);
    rd_word(2'b11, w);
    chk("R11 memory untouched", w, pat(7));

    // R9 read bus holds without read strobes
    q0 = host_dout;
    hbyte(2'b11, 1'b0, 1'b0, 8'h44, q);
    repeat (3) @(negedge clk);
    chk("R9 dout held", {8'h00, host_dout}, {8'h00, q0});

    // R7/R8 ordering: read then write with advance
    wr_word(2'b10, 16'd20);
    rd_word(2'b01, w);
    chk("R8 read before advance", w, pat(20));
    wr_word(2'b01, 16'h6D2C);
    rd_word(2'b10, w);
    chk("R7 pointer after advance write", w, 16'd22);
    rd_word(2'b11, w);
    chk("R7 stored at advanced address", w, 16'h6D2C);
    wr_word(2'b10, 16'd21);
    rd_word(2'b11, w);
    chk("R7 skipped word intact", w, pat(21));

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule